// File: doc/BRIEF.md
# Bus Occurrence Event Counter

This block watches the per-cycle status of a shared internal bus and counts how often certain events occur, for performance tuning. Three bus masters can own the bus: a primary bridge, a secondary bridge and a core interface. The block counts how many transactions each master starts. It also counts how many separate times a back-off signal is raised, and how many retries are issued because the inbound write queue is full. Retries that answer configuration writes are left out of that count.

A small register interface selects the event group. In grant mode the three per-master grant counters run. In bus-event mode the back-off and retry counters run. After reset the mode is off and nothing counts. Software reads each counter at its own address. Writing to a counter's address clears that counter. Changing the mode clears every counter, so counts from different groups are never mixed. Counters stop at all-ones instead of wrapping.

Top module: `occ_bus_event_counter`

## Requirements
- R1: After reset the mode reads 0 (off) and every counter reads 0.
- R2: In mode 1 (grant group), a transaction whose master ID is 1 (primary bridge), 2 (secondary bridge) or 3 (core interface) adds one to that master's counter. A transaction with master ID 0 counts nowhere.
- R3: A transaction runs from a cycle with `bus_valid` high until a cycle that has both `bus_valid` and `bus_last` high. Each transaction is counted once, on its first cycle. A valid cycle that follows a last cycle starts a new transaction.
- R4: In mode 2 (bus-event group), the back-off counter adds one for each low-to-high change of `backoff`, however long the signal stays high.
- R5: In mode 2, each cycle with `retry_valid` high and `retry_cmd` other than 4'hB adds one to the retry counter.
- R6: A retry with `retry_cmd` equal to 4'hB (configuration write) never changes the retry counter.
- R7: A counter at all-ones (2^CNT_W - 1) stays there on further events.
- R8: Writing any value to counter addresses 1 to 5 clears that counter to zero. In the same cycle, the clear wins over an increment.
- R9: Writing a new mode to address 0 clears all counters. Writing the mode that is already set clears nothing.
- R10: In mode 0 or 3 no counter changes. In mode 1 back-off and retry events are not counted. In mode 2 grants are not counted.
- R11: The read map is as follows. Address 0 returns the mode in bits [1:0]. Addresses 1, 2 and 3 return the primary, secondary and core grant counters. Address 4 returns the back-off counter and address 5 the retry counter. Unused addresses read 0. The read is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus carries a transaction this cycle |
| bus_last | input | 1 | Final cycle of the current transaction |
| bus_master | input | 2 | ID of the owning master (1 primary, 2 secondary, 3 core) |
| backoff | input | 1 | Back-off signal level |
| retry_valid | input | 1 | A retry is issued this cycle because the inbound write queue is full |
| retry_cmd | input | 4 | Command of the retried transaction |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Register write address |
| reg_wdata | input | 2 | Write data (mode value at address 0) |
| reg_raddr | input | ADDR_W | Register read address |
| reg_rdata | output | DATA_W | Read data for `reg_raddr` |

## Verification
The grant counters are tested with several transaction shapes. A multi-cycle transaction must count once. Back-to-back single-cycle transactions must count once each, which separates first-cycle detection from level detection. A master-0 transaction must count nowhere. Back-off is tested with a long pulse and a one-cycle pulse, which separates edge counting from cycle counting. Retries use a mix of ordinary and configuration-write commands to show that the filter works. Further patterns test a clear and an increment in the same cycle, a long run of retries into saturation with a narrow counter, and rewriting the same mode versus a new one.

// File: rtl/occ_pkg.sv
package occ_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_GRANT = 2'd1,
    MODE_BUS   = 2'd2,
    MODE_RSVD  = 2'd3
  } occ_mode_e;

  localparam int NUM_CNT  = 5;
  localparam int NUM_MST  = 3;
  localparam int EV_PRI   = 0;
  localparam int EV_SEC   = 1;
  localparam int EV_CORE  = 2;
  localparam int EV_BOFF  = 3;
  localparam int EV_RETRY = 4;

  localparam logic [3:0] CMD_CFG_WR = 4'hB;

  // a retry is counted unless it answers a configuration write
  function automatic logic counts_retry(logic valid, logic [3:0] cmd);
    return valid && (cmd != CMD_CFG_WR);
  endfunction

  // which counters an event group enables
  function automatic logic [NUM_CNT-1:0] group_mask(occ_mode_e m);
    case (m)
      MODE_GRANT: return 5'b00111;
      MODE_BUS:   return 5'b11000;
      default:    return 5'b00000;
    endcase
  endfunction
endpackage

// File: rtl/occ_event_detect.sv
module occ_event_detect
  import occ_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_last,
  input  logic [1:0]         bus_master,
  input  logic               backoff,
  input  logic               retry_valid,
  input  logic [3:0]         retry_cmd,
  output logic [NUM_CNT-1:0] evt_raw
);
  logic prev_valid, prev_last, prev_boff;
  logic txn_first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_valid <= 1'b0;
      prev_last  <= 1'b0;
      prev_boff  <= 1'b0;
    end else begin
      prev_valid <= bus_valid;
      prev_last  <= bus_valid && bus_last;
      prev_boff  <= backoff;
    end
  end

  always_comb begin
    txn_first = bus_valid && (!prev_valid || prev_last);
    evt_raw   = '0;
    for (int m = 0; m < NUM_MST; m++)
      evt_raw[m] = txn_first && (bus_master == 2'(m + 1));
    evt_raw[EV_BOFF]  = backoff && !prev_boff;
    evt_raw[EV_RETRY] = counts_retry(retry_valid, retry_cmd);
  end
endmodule

// File: rtl/occ_sat_counter.sv
module occ_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  function automatic logic [W-1:0] sat_next(logic [W-1:0] v);
    return (v == '1) ? v : v + W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= sat_next(cnt);
  end
endmodule

// File: rtl/occ_bus_event_counter.sv
module occ_bus_event_counter
  import occ_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_last,
  input  logic [1:0]        bus_master,
  input  logic              backoff,
  input  logic              retry_valid,
  input  logic [3:0]        retry_cmd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [1:0]        reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam logic [ADDR_W-1:0] MODE_ADDR = '0;

  occ_mode_e                      mode_q;
  logic                           mode_wr, mode_chg;
  logic [NUM_CNT-1:0]             evt_raw, evt_en, clr_vec;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_q;

  assign mode_wr  = reg_wr && (reg_waddr == MODE_ADDR);
  assign mode_chg = mode_wr && (occ_mode_e'(reg_wdata) != mode_q);

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= MODE_OFF;
    else if (mode_wr) mode_q <= occ_mode_e'(reg_wdata);
  end

  occ_event_detect u_detect (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_last(bus_last), .bus_master(bus_master),
    .backoff(backoff), .retry_valid(retry_valid), .retry_cmd(retry_cmd),
    .evt_raw(evt_raw)
  );

  assign evt_en = evt_raw & group_mask(mode_q);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign clr_vec[i] = mode_chg ||
                        (reg_wr && (reg_waddr == ADDR_W'(i + 1)));
    occ_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .clr(clr_vec[i]), .inc(evt_en[i]), .cnt(cnt_q[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_raddr == MODE_ADDR) reg_rdata = DATA_W'(mode_q);
    for (int i = 0; i < NUM_CNT; i++)
      if (reg_raddr == ADDR_W'(i + 1)) reg_rdata = DATA_W'(cnt_q[i]);
  end
endmodule

// File: rtl/occ_checker.sv
module occ_checker
  import occ_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input occ_mode_e                     mode_q,
  input logic                          reg_wr,
  input logic                          bus_valid,
  input logic                          bus_last,
  input logic                          backoff,
  input logic                          retry_valid,
  input logic [3:0]                    retry_cmd,
  input logic [NUM_CNT-1:0]            evt_raw,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q
);
  // R3: no grant event inside a transaction that is already running
  p_grant_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && bus_valid && $past(bus_valid) && !$past(bus_last))
      |-> (evt_raw[EV_CORE:EV_PRI] == '0));

  // R4: back-off that is held does not produce a second event
  p_boff_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && backoff && $past(backoff)) |-> !evt_raw[EV_BOFF]);

  // R6: configuration-write retries are filtered
  p_cfg_retry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_valid && retry_cmd == CMD_CFG_WR) |-> !evt_raw[EV_RETRY]);

  // R7: a full counter stays full unless cleared
  p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q[EV_RETRY] == '1) |=> (cnt_q[EV_RETRY] == '1 || cnt_q[EV_RETRY] == '0));

  // R9: a new mode starts from all-zero counters
  p_mode_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> (cnt_q == '0));

  // R10: an inactive mode freezes every counter
  p_off_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_OFF || mode_q == MODE_RSVD) && !reg_wr) |=> $stable(cnt_q));
endmodule

bind occ_bus_event_counter occ_checker #(.CNT_W(CNT_W)) u_occ_checker (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .reg_wr(reg_wr),
  .bus_valid(bus_valid), .bus_last(bus_last), .backoff(backoff),
  .retry_valid(retry_valid), .retry_cmd(retry_cmd),
  .evt_raw(evt_raw), .cnt_q(cnt_q)
);

// File: tb/test_occ_bus_event_counter.sv
`timescale 1ns/1ps
module test_occ_bus_event_counter;
  localparam int CNT_W  = 6;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int SAT    = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 0, bus_last = 0, backoff = 0, retry_valid = 0, reg_wr = 0;
  logic [1:0] bus_master = 0, reg_wdata = 0;
  logic [3:0] retry_cmd = 0;
  logic [ADDR_W-1:0] reg_waddr = 0, reg_raddr = 0;
  logic [DATA_W-1:0] reg_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  occ_bus_event_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_occ_bus_event_counter (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_last(bus_last),
    .bus_master(bus_master), .backoff(backoff), .retry_valid(retry_valid),
    .retry_cmd(retry_cmd), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata));

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string req, int addr, int exp);
    reg_raddr = ADDR_W'(addr);
    #1;
    checks++;
    if (reg_rdata !== DATA_W'(exp)) begin
      errors++;
      $display("FAIL %s addr %0d: actual %0d expected %0d", req, addr, reg_rdata, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    reg_wr = 1; reg_waddr = ADDR_W'(addr); reg_wdata = 2'(data);
    step();
    reg_wr = 0;
  endtask

  task automatic txn(int id, int len);
    for (int c = 0; c < len; c++) begin
      bus_valid = 1; bus_master = 2'(id); bus_last = (c == len - 1);
      step();
    end
    bus_valid = 0; bus_last = 0; bus_master = 0;
  endtask

  task automatic t_reset;
    for (int a = 0; a < 6; a++) chk("R1", a, 0);
  endtask

  task automatic t_grants;
    wr(0, 1);
    chk("R11", 0, 1);
    txn(1, 3);                 chk("R3", 1, 1);
    txn(2, 1); txn(2, 1);      chk("R3", 2, 2);
    txn(3, 2);                 chk("R2", 3, 1);
    txn(0, 2);
    chk("R2", 1, 1); chk("R2", 2, 2); chk("R2", 3, 1);
    backoff = 1; step(); backoff = 0; step();
    retry_valid = 1; step(); retry_valid = 0;
    chk("R10", 4, 0); chk("R10", 5, 0);
  endtask

  task automatic t_bus_events;
    wr(0, 2);
    chk("R9", 1, 0); chk("R9", 2, 0); chk("R9", 3, 0);
    backoff = 1; step(3); backoff = 0; step();
    backoff = 1; step(); backoff = 0; step();
    chk("R4", 4, 2);
    retry_valid = 1; retry_cmd = 4'h7; step(2);
    retry_cmd = 4'hB; step(3);
    retry_valid = 0;
    chk("R5", 5, 2); chk("R6", 5, 2);
    txn(1, 2); chk("R10", 1, 0);
    wr(0, 2);  chk("R9", 4, 2);
  endtask

  task automatic t_clear;
    reg_wr = 1; reg_waddr = 4; backoff = 1;
    step();
    reg_wr = 0; backoff = 0; step();
    chk("R8", 4, 0); chk("R8", 5, 2);
    wr(5, 3); chk("R8", 5, 0);
  endtask

  task automatic t_saturate;
    retry_valid = 1; retry_cmd = 4'h2; step(SAT + 7); retry_valid = 0;
    chk("R7", 5, SAT);
  endtask

  task automatic t_inactive;
    wr(0, 0);
    chk("R9", 5, 0);
    txn(1, 1); backoff = 1; retry_valid = 1; step(); backoff = 0; retry_valid = 0; step();
    for (int a = 1; a < 6; a++) chk("R10", a, 0);
    wr(0, 3); chk("R11", 0, 3);
    txn(3, 1); retry_valid = 1; step(); retry_valid = 0;
    chk("R10", 3, 0); chk("R10", 5, 0); chk("R11", 7, 0);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step();
    t_reset();
    t_grants();
    t_bus_events();
    t_clear();
    t_saturate();
    t_inactive();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule